// File: doc/BRIEF.md
# Serial DAC Frame Demultiplexer

This block sits between a processor's serial port and the analog output stage of a multi-channel supply controller. The analog stage has one shared 16-bit main converter whose output is steered by a 16-way analog switch into 16 sample-and-hold channels. A seventeenth sample-and-hold channel captures a reference level used for first-order gain correction. Two 12-bit trim converters adjust the offset and gain of the main converter. Software refreshes every channel about once per millisecond by sending one serial frame per channel.

Each frame carries 24 bits: a 4-bit command, a 4-bit channel number and a 16-bit value. The serial clock, frame sync and data are brought into the system clock domain through two-flop synchronizers. The frame is decoded when frame sync falls. A main-converter command loads the converter, waits a programmable settling time, and then closes the addressed switch and fires the sample strobe for a programmable hold time. A trim command loads one of the trim converters. Commands that are not defined and conflicting frames raise a sticky error flag.

Top module: `sh_dac_demux`

## Requirements
- R1: A frame is the sequence of `ser_dat` bits sampled on rising edges of `ser_clk` while `ser_fs` is high, most significant bit first. The order is command[3:0], then channel[3:0], then value[15:0]. The frame is decoded after `ser_fs` falls.
- R2: Command 4'h1 sets `main_data` to the 16-bit value and raises `main_load` for exactly one clock cycle.
- R3: After the `main_load` cycle, no switch is selected for `settle_cyc` cycles. Then `sw_sel` carries a single set bit at the channel-number position and `sh_stb` is high, both for `hold_cyc` cycles. A hold value of 0 acts as 1. Both settle and hold are sampled when the frame is decoded.
- R4: Command 4'h4 runs the same sequence as R3, except that `ref_sel` is asserted in place of `sw_sel`, which stays zero.
- R5: Command 4'h2 sets `trim_data` to the low 12 bits of the value and pulses `ofs_load` for one cycle. Command 4'h3 does the same with `gain_load`. `main_data` is not changed by either.
- R6: Any other command value changes no output except `err`. `err` then rises and stays high until reset.
- R7: A frame whose bit count is not exactly 24 is discarded. It causes no load, no strobe and no error.
- R8: A command 4'h1 or 4'h4 frame decoded while a main sequence is still running is dropped, leaving `main_data` unchanged, and sets `err`.
- R9: During and after reset, all outputs are zero.
- R10: At most one bit of `sw_sel` is ever set. No switch or reference select is asserted in the `main_load` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_fs | input | 1 | Frame sync, high for the frame |
| ser_dat | input | 1 | Serial data |
| settle_cyc | input | CNT_W | Settling cycles after a main load |
| hold_cyc | input | CNT_W | Switch/strobe hold cycles |
| main_data | output | DW | Main converter input word |
| main_load | output | 1 | Main converter load pulse |
| trim_data | output | TW | Trim converter input word |
| ofs_load | output | 1 | Offset trim load pulse |
| gain_load | output | 1 | Gain trim load pulse |
| sw_sel | output | 16 | One-hot analog switch selects |
| ref_sel | output | 1 | Reference sample-and-hold select |
| sh_stb | output | 1 | Sample strobe |
| err | output | 1 | Sticky error flag |

## Verification
A shift register or bit counter that has slipped shows up at the ports within one frame. The effects are a wrong channel bit in `sw_sel`, a wrong `main_data`, or a frame that is silently lost or wrongly accepted. A sequencer fault shows in the gap between `main_load` and `sh_stb`, or in the width of the strobe, on the very next main write. The bench therefore measures those two intervals in cycles against the settle and hold inputs. It also checks that trim commands, bad commands and short or long frames leave `main_data` and the strobes untouched.

// File: rtl/sh_dac_demux.sv
module sh_dac_demux #(
  parameter int DW    = 16,
  parameter int TW    = 12,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_fs,
  input  logic             ser_dat,
  input  logic [CNT_W-1:0] settle_cyc,
  input  logic [CNT_W-1:0] hold_cyc,
  output logic [DW-1:0]    main_data,
  output logic             main_load,
  output logic [TW-1:0]    trim_data,
  output logic             ofs_load,
  output logic             gain_load,
  output logic [15:0]      sw_sel,
  output logic             ref_sel,
  output logic             sh_stb,
  output logic             err
);
  localparam int FW  = DW + 8;
  localparam int BCW = $clog2(FW + 2);
  localparam logic [BCW-1:0] FW_B  = BCW'(FW);
  localparam logic [BCW-1:0] SAT_B = BCW'(FW + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SETTLE, S_HOLD} st_t;

  logic [2:0]       ck_q;
  logic [1:0]       fs_q, dt_q;
  logic             fs_d;
  logic [FW-1:0]    sreg;
  logic [BCW-1:0]   bcnt;
  st_t              state;
  logic [CNT_W-1:0] tmr, hold_r;
  logic [3:0]       chan;
  logic             to_ref;

  wire rise = ck_q[1] & ~ck_q[2];
  wire fend = fs_d & ~fs_q[1];
  wire fok  = fend && (bcnt == FW_B);
  wire [3:0]    f_cmd = sreg[FW-1 -: 4];
  wire [3:0]    f_ch  = sreg[FW-5 -: 4];
  wire [DW-1:0] f_val = sreg[DW-1:0];
  wire          busy  = (state != S_IDLE);
  wire [CNT_W-1:0] hold_m1 = (hold_r == '0) ? '0 : hold_r - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0; fs_q <= '0; dt_q <= '0; fs_d <= 1'b0;
    end else begin
      ck_q <= {ck_q[1:0], ser_clk};
      fs_q <= {fs_q[0], ser_fs};
      dt_q <= {dt_q[0], ser_dat};
      fs_d <= fs_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0; bcnt <= '0; state <= S_IDLE; tmr <= '0; hold_r <= '0;
      chan <= '0; to_ref <= 1'b0; main_data <= '0; trim_data <= '0;
      ofs_load <= 1'b0; gain_load <= 1'b0; err <= 1'b0;
    end else begin
      ofs_load  <= 1'b0;
      gain_load <= 1'b0;
      if (rise && fs_q[1]) begin
        sreg <= {sreg[FW-2:0], dt_q[1]};
        if (bcnt != SAT_B) bcnt <= bcnt + 1'b1;
      end
      if (fend) bcnt <= '0;

      case (state)
        S_LOAD, S_SETTLE:
          if (tmr == '0) begin
            state <= S_HOLD;
            tmr   <= hold_m1;
          end else begin
            state <= S_SETTLE;
            tmr   <= tmr - 1'b1;
          end
        S_HOLD:
          if (tmr == '0) state <= S_IDLE;
          else           tmr   <= tmr - 1'b1;
        default: ;
      endcase

      if (fok) begin
        case (f_cmd)
          4'h1, 4'h4:
            if (busy) err <= 1'b1;
            else begin
              main_data <= f_val;
              chan      <= f_ch;
              to_ref    <= (f_cmd == 4'h4);
              hold_r    <= hold_cyc;
              tmr       <= settle_cyc;
              state     <= S_LOAD;
            end
          4'h2: begin trim_data <= f_val[TW-1:0]; ofs_load  <= 1'b1; end
          4'h3: begin trim_data <= f_val[TW-1:0]; gain_load <= 1'b1; end
          default: err <= 1'b1;
        endcase
      end
    end
  end

  assign main_load = (state == S_LOAD);
  assign sh_stb    = (state == S_HOLD);
  assign ref_sel   = sh_stb & to_ref;
  assign sw_sel    = (sh_stb && !to_ref) ? (16'b1 << chan) : 16'b0;

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_sel));
  assert_load_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    main_load |-> (sw_sel == 16'b0 && !ref_sel && !sh_stb));
  assert_load_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    main_load |=> !main_load);
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_trim_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ofs_load && gain_load));
  assert_ref_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sel |-> (sw_sel == 16'b0));
  assert_data_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_stb |-> $stable(main_data));
endmodule

// File: tb/tb_sh_dac_demux.sv
module tb_sh_dac_demux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_fs = 1'b0, ser_dat = 1'b0;
  logic [7:0] settle_cyc = '0, hold_cyc = '0;
  logic [15:0] main_data;
  logic main_load;
  logic [11:0] trim_data;
  logic ofs_load, gain_load;
  logic [15:0] sw_sel;
  logic ref_sel, sh_stb, err;

  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;

  sh_dac_demux dut (.*);

  // monitor
  logic clr = 1'b1;
  int nload, nofs, ngain, gap, since, hlen, nref;
  logic [15:0] swcap;
  logic armed, seen;
  always @(negedge clk) begin
    cyc++;
    if (clr) begin
      nload = 0; nofs = 0; ngain = 0; gap = -1; since = 0; hlen = 0; nref = 0;
      swcap = '0; armed = 1'b0; seen = 1'b0;
    end else begin
      if (main_load) begin nload++; since = 0; armed = 1'b1; seen = 1'b0; end
      else if (armed) since++;
      if (sh_stb) begin
        if (!seen) begin gap = since; seen = 1'b1; end
        hlen++;
      end
      swcap |= sw_sel;
      if (ref_sel) nref++;
      if (ofs_load) nofs++;
      if (gain_load) ngain++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d, input int nb);
    logic [23:0] w;
    w = {c, a, d};
    @(negedge clk);
    ser_fs = 1'b1;
    for (int i = 0; i < nb; i++) begin
      ser_dat = (i < 24) ? w[23-i] : 1'b0;
      ser_clk = 1'b0; waitc(4);
      ser_clk = 1'b1; waitc(4);
    end
    ser_clk = 1'b0; waitc(4);
    ser_fs = 1'b0;
  endtask

  // {cmd, chan, value, settle, hold}
  localparam logic [39:0] VEC [0:7] = '{
    {4'h1, 4'd3,  16'hA5C3, 8'd2, 8'd3},
    {4'h1, 4'd15, 16'h0001, 8'd0, 8'd1},
    {4'h1, 4'd0,  16'hFFFF, 8'd5, 8'd0},
    {4'h2, 4'd7,  16'h9ABC, 8'd0, 8'd0},
    {4'h3, 4'd1,  16'h1234, 8'd0, 8'd0},
    {4'h4, 4'd9,  16'h7E01, 8'd3, 8'd2},
    {4'h1, 4'd8,  16'h8000, 8'd1, 8'd4},
    {4'hA, 4'd2,  16'h5555, 8'd1, 8'd1}
  };

  initial begin
    logic [15:0] exp_main;
    logic [11:0] exp_trim;
    logic exp_err;
    waitc(3);
    chk("R9 main_data at reset", {16'h0, main_data}, 0);
    chk("R9 strobes at reset", {main_load, ofs_load, gain_load, ref_sel, sh_stb, err}, 0);
    rst_n = 1'b1;
    waitc(3);
    chk("R9 sw_sel after reset", {16'h0, sw_sel}, 0);
    exp_main = '0; exp_trim = '0; exp_err = 1'b0;

    // R7 short and long frames
    settle_cyc = 8'd1; hold_cyc = 8'd1;
    clr = 1'b1; waitc(1); clr = 1'b0;
    send(4'h1, 4'd5, 16'h1357, 20);
    waitc(40);
    send(4'h1, 4'd5, 16'h2468, 25);
    waitc(40);
    chk("R7 no load on bad length", nload, 0);
    chk("R7 main_data unchanged", {16'h0, main_data}, 0);
    chk("R7 no err on bad length", {31'h0, err}, 0);
    chk("R7 no strobe on bad length", hlen, 0);

    // R1..R6 table
    foreach (VEC[k]) begin
      logic [3:0] c, a; logic [15:0] d; logic [7:0] s, h;
      {c, a, d, s, h} = VEC[k];
      settle_cyc = s; hold_cyc = h;
      clr = 1'b1; waitc(1); clr = 1'b0;
      send(c, a, d, 24);
      waitc(300);
      if (c == 4'h1 || c == 4'h4) begin
        exp_main = d;
        chk("R1 R2 main_data", {16'h0, main_data}, {16'h0, exp_main});
        chk("R2 one load pulse", nload, 1);
        chk("R3 settle gap", gap, s + 1);
        chk("R3 hold length", hlen, (h == 0) ? 1 : h);
        if (c == 4'h1) begin
          chk("R1 R3 switch select", {16'h0, swcap}, {16'h0, 16'b1 << a});
          chk("R4 no ref on channel write", nref, 0);
        end else begin
          chk("R4 ref length", nref, (h == 0) ? 1 : h);
          chk("R4 no switch on ref write", {16'h0, swcap}, 0);
        end
      end else if (c == 4'h2 || c == 4'h3) begin
        exp_trim = d[11:0];
        chk("R5 trim_data", {20'h0, trim_data}, {20'h0, exp_trim});
        chk("R5 offset pulses", nofs, (c == 4'h2) ? 1 : 0);
        chk("R5 gain pulses", ngain, (c == 4'h3) ? 1 : 0);
        chk("R5 main untouched", {16'h0, main_data}, {16'h0, exp_main});
        chk("R5 no main load", nload, 0);
      end else begin
        exp_err = 1'b1;
        chk("R6 err set", {31'h0, err}, {31'h0, exp_err});
        chk("R6 main untouched", {16'h0, main_data}, {16'h0, exp_main});
        chk("R6 no load", nload + nofs + ngain + hlen, 0);
      end
    end
    waitc(50);
    chk("R6 err still set", {31'h0, err}, 1);

    // R9 reset clears, R8 busy drop
    rst_n = 1'b0; waitc(2);
    chk("R9 err cleared", {31'h0, err}, 0);
    chk("R9 main cleared", {16'h0, main_data}, 0);
    rst_n = 1'b1; waitc(2);
    settle_cyc = 8'd200; hold_cyc = 8'd200;
    clr = 1'b1; waitc(1); clr = 1'b0;
    send(4'h1, 4'd6, 16'hC0DE, 24);
    send(4'h1, 4'd2, 16'hBEEF, 24);
    waitc(500);
    chk("R8 first write kept", {16'h0, main_data}, {16'h0, 16'hC0DE});
    chk("R8 single load", nload, 1);
    chk("R8 err on busy", {31'h0, err}, 1);
    chk("R8 channel of first write", {16'h0, swcap}, {16'h0, 16'h0040});
    chk("R10 hold of first write", hlen, 200);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule